// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block turns single-beat read and write requests from an on-chip valid/ready port into pin-level cycles for an external asynchronous static RAM of 512K bytes. It drives the active-low select, output-enable and write-enable strobes, the 19-bit address and a tri-state 8-bit data bus. Every phase of an access lasts a whole number of clock periods. Each count comes from a nanosecond minimum and the clock-period parameter: the minimum is divided by the period, rounded up, and never less than one. This is how the strobe pulse, data setup, access and bus-release times are met.

After reset the block refuses all requests until a power-up interval has passed. Between accesses it keeps the RAM deselected so that the RAM sits in its low-power state. A read returns its byte on a one-cycle response strobe. A write that follows a read waits for extra quiet cycles, so the RAM has released the bus before the controller drives it.

Top module: `sram_seq`

## Requirements
- R1: After reset, `req_ready` stays low and `mem_sel_n` stays high for exactly ceil(`PWRUP_NS`/`CLK_NS`) clock cycles. `req_ready` rises after that.
- R2: Whenever `req_ready` is high (idle), all three strobes `mem_sel_n`, `mem_rd_n` and `mem_wr_n` are high.
- R3: A write holds `mem_sel_n` and `mem_wr_n` low together for WR cycles, where WR is the largest of the pulse, data-setup and cycle-minus-one counts. `mem_rd_n` stays high during that time. The write byte is driven on `mem_dq` for the whole pulse and is still driven in the cycle the strobes rise.
- R4: A read holds `mem_sel_n` and `mem_rd_n` low with `mem_wr_n` high for AA cycles, where AA = ceil(`T_ACC_NS`/`CLK_NS`). The bus is sampled at the end of the last of those cycles. In the following cycle `rsp_valid` is high for exactly one cycle, with the byte on `rsp_data`.
- R5: The controller drives `mem_dq` only while `mem_wr_n` is low or in the single cycle after it rises.
- R6: When a write follows a read, at least TA+1 cycles with all strobes high separate the rise of `mem_rd_n` from the fall of `mem_wr_n`, where TA = ceil(`T_REL_NS`/`CLK_NS`).
- R7: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. While a sequence runs, `req_ready` is low and a held request is not taken twice: each read gives exactly one response.
- R8: A byte written to an address is returned by every later read of that address until the next write there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | DATA_W | Read byte |
| mem_sel_n | output | 1 | RAM chip select, active low |
| mem_rd_n | output | 1 | RAM output enable, active low |
| mem_wr_n | output | 1 | RAM write enable, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq | inout | DATA_W | RAM data bus |

## Verification
The delivery of a read response and the acceptance of the next request can fall in the same cycle, because `rsp_valid` and the return of `req_ready` share the first idle cycle after a read. The driver task keeps the next request waiting on the port as soon as the previous one is taken. Reads are then followed at once by other reads and by writes, so the turnaround path also starts in that same cycle. The scoreboard must see each response exactly once. The bench's RAM model must report no bus overlap, short pulse or early data while a write is being started in the same cycle that a read completes.

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq #(
  parameter int CLK_NS    = 10,
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int PWRUP_NS  = 1000000,
  parameter int T_ACC_NS  = 12,
  parameter int T_WP_NS   = 10,
  parameter int T_SU_NS   = 7,
  parameter int T_WC_NS   = 12,
  parameter int T_REL_NS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_sel_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int AA_CYC  = cyc(T_ACC_NS);
  localparam int TA_CYC  = cyc(T_REL_NS);
  localparam int PWR_CYC = cyc(PWRUP_NS);
  localparam int WP_A    = cyc(T_WP_NS) > cyc(T_SU_NS) ? cyc(T_WP_NS) : cyc(T_SU_NS);
  localparam int WR_CYC  = WP_A > (cyc(T_WC_NS) - 1) ? WP_A : (cyc(T_WC_NS) - 1);
  localparam int CNT_W   = $clog2(PWR_CYC + 1) + 1;

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_TURN, S_WR, S_WEND, S_RD} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic              last_rd;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              drv;

  wire take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PWR;
      cnt       <= '0;
      last_rd   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      cnt       <= cnt + 1'b1;
      case (state)
        S_PWR:
          if (cnt == CNT_W'(PWR_CYC - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end
        S_IDLE: begin
          cnt <= '0;
          if (take) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (!req_write) state <= S_RD;
            else begin
              last_rd <= 1'b0;
              state   <= last_rd ? S_TURN : S_WR;
            end
          end
        end
        S_TURN:
          if (cnt == CNT_W'(TA_CYC - 1)) begin
            state <= S_WR;
            cnt   <= '0;
          end
        S_WR:
          if (cnt == CNT_W'(WR_CYC - 1)) begin
            state <= S_WEND;
            cnt   <= '0;
          end
        S_WEND: state <= S_IDLE;
        S_RD:
          if (cnt == CNT_W'(AA_CYC - 1)) begin
            rsp_data  <= mem_dq;
            rsp_valid <= 1'b1;
            last_rd   <= 1'b1;
            state     <= S_IDLE;
            cnt       <= '0;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign mem_sel_n = !(state == S_WR || state == S_RD);
  assign mem_rd_n  = (state != S_RD);
  assign mem_wr_n  = (state != S_WR);
  assign mem_addr  = addr_q;
  assign drv       = (state == S_WR) || (state == S_WEND);
  assign mem_dq    = drv ? wdata_q : {DATA_W{1'bz}};

  a_r1_no_access_in_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWR) |-> (mem_sel_n && !req_ready));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && mem_rd_n && mem_wr_n));
  a_r3_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_rd_n && !mem_sel_n));
  a_r4_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (!mem_wr_n || $past(!mem_wr_n)));
  a_r6_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> mem_wr_n);
endmodule

// File: tb/sram_seq_test.sv
`timescale 1ns/1ps
module sram_seq_test;
  localparam int CLK_NS = 8;
  localparam int PWR    = 100;
  localparam int AA     = 2;
  localparam int WR     = 2;
  localparam int TA     = 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  wire         req_ready, rsp_valid;
  wire  [7:0]  rsp_data;
  wire         mem_sel_n, mem_rd_n, mem_wr_n;
  wire  [18:0] mem_addr;
  wire  [7:0]  mem_dq;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] shadow[int];
  logic [7:0] ram[int];

  always #4 clk = ~clk;

  sram_seq #(.CLK_NS(CLK_NS), .PWRUP_NS(PWR*CLK_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_sel_n(mem_sel_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model: access-time validity, output release tail, pulse/setup/overlap checks
  wire  rd_cond = !mem_sel_n && !mem_rd_n && mem_wr_n;
  wire  w_act   = !mem_sel_n && !mem_wr_n;
  logic tail = 0, ok = 0;
  int   gen = 0;
  realtime t_wstart, t_dq;
  wire  m_en = rd_cond || tail;
  wire [7:0] m_word = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
  assign mem_dq = m_en ? (ok ? m_word : ~m_word) : 8'bz;

  always @(mem_addr, mem_sel_n, mem_rd_n, mem_wr_n) begin
    gen = gen + 1;
    ok  = 0;
    fork
      begin
        automatic int g = gen;
        #12;
        if (g == gen) ok = 1;
      end
    join_none
  end
  always @(negedge rd_cond) begin tail = 1; #6 tail = 0; end
  always @(posedge w_act) t_wstart = $realtime;
  always @(mem_dq) if (w_act) t_dq = $realtime;
  always @(negedge w_act) begin
    check("R3 pulse>=10ns", ($realtime - t_wstart) >= 10.0, 1);
    check("R3 setup>=7ns", ($realtime - t_dq) >= 7.0, 1);
    ram[int'(mem_addr)] = mem_dq;
  end
  always @(negedge clk) if (rst_n && m_en && !mem_wr_n) check("R6 bus overlap", 1, 0);

  // strobe length monitors
  int rd_run = 0, wr_run = 0, quiet = 99;
  logic after_rd = 0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_rd_n) rd_run++;
    else if (rd_run != 0) begin check("R4 read strobe cycles", rd_run, AA); rd_run = 0; after_rd = 1; quiet = 0; end
    if (!mem_wr_n) begin
      if (wr_run == 0 && after_rd) begin check("R6 quiet cycles", quiet >= TA + 1, 1); after_rd = 0; end
      if (wr_run == 0) check("R3 oe high in write", mem_rd_n, 1);
      wr_run++;
    end else begin
      if (wr_run != 0) begin check("R3 write strobe cycles", wr_run, WR); wr_run = 0; end
      if (mem_rd_n && mem_sel_n) quiet++;
    end
    if (req_ready) check("R2 idle strobes", {mem_sel_n, mem_rd_n, mem_wr_n}, 3'b111);
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) check("R7 unexpected response", 1, 0);
    else check("R4 R8 read data", rsp_data, exp_q.pop_front());
  end

  task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (w) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 0);
    check("R1 reset strobes", {mem_sel_n, mem_rd_n, mem_wr_n, rsp_valid}, 4'b1110);
    rst_n = 1;
    begin
      automatic int n = 0;
      req_valid = 1; req_write = 0; req_addr = 19'h1;
      while (!req_ready) begin
        @(negedge clk); n++;
        if (!req_ready && !mem_sel_n) check("R1 select during wait", 1, 0);
      end
      req_valid = 0;
      check("R1 power-up cycles", n, PWR);
    end
    issue(1, 19'h00000, 8'h3C);
    issue(1, 19'h7FFFF, 8'hA5);
    issue(0, 19'h00000, 0);
    issue(0, 19'h7FFFF, 0);
    issue(1, 19'h12345, 8'hFF);
    issue(0, 19'h12345, 0);
    issue(1, 19'h12345, 8'h00);
    issue(0, 19'h12345, 0);
    issue(0, 19'h40000, 0);
    for (int i = 0; i < 16; i++) issue(1, 19'(i * 4099), 8'(i * 37 + 5));
    for (int i = 0; i < 16; i++) begin
      issue(0, 19'(i * 4099), 0);
      if (i % 3 == 0) issue(1, 19'(i * 4099 + 1), 8'(i));
    end
    for (int i = 0; i < 16; i++) if (i % 3 == 0) issue(0, 19'(i * 4099 + 1), 0);
    repeat (10) @(negedge clk);
    check("R7 all responses seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule